// File: doc/BRIEF.md
# Phase-Locked Dual PWM Timer Group

This block is a three-channel timer group. One master channel sets a common period and two slave channels each drive one PWM pin. The master is a reloading down-counter. Each time it passes through zero it emits a one-cycle period pulse and reloads from its data register. That same event restarts both slaves as one-shot down-counters. A slave's pin goes active one count tick after the master event and stays active for as many ticks as its data value. Both pins therefore share the master period and stay phase-locked to it, and each has its own duty.

Counting advances only on clock edges where the count-enable input is high. All three channels start and stop together through single-cycle trigger inputs. Data registers can be rewritten while the group runs, but a value is only used at a load event, so a new value takes effect at the next master event. When the group stops, the counters and pin levels freeze. While a pin's output enable is low, software can set that pin's level directly.

Top module: `phase_locked_pwm`

## Requirements
- R1: After a synchronous active-low reset, `mst_count`, `slv_count`, `period_irq`, `pwm_out` and all data registers read zero and the group is stopped.
- R2: A `start_trig` pulse loads the master counter from the master data register (written with `wr_ch`=0; `wr_ch`=1 addresses slave A driving `pwm_out[0]`, `wr_ch`=2 slave B driving `pwm_out[1]`, `wr_ch`=3 is ignored). After that, each enabled tick lowers the master counter by one.
- R3: On an enabled tick that finds the master counter at zero, the counter reloads from its data register and `period_irq` is high for the following clock cycle only. The period is the master data value M plus one ticks.
- R4: Each slave loads its data value S at the master event. Its pin goes high one tick later, stays high for exactly S ticks and then goes low. It stays low until the next master event.
- R5: A slave data value of zero keeps its pin low for the whole period.
- R6: A slave data value of M+1 or more keeps its pin high across period boundaries with no low cycle.
- R7: A data register write made during a period does not alter that period's counting. The master reload value and the slave widths change from the next master event onward.
- R8: A `stop_trig` pulse freezes all counters and both pins at their current values until the next start.
- R9: With `cnt_en` low, no counter and no timer-driven pin changes.
- R10: While `out_en[i]` is low, a `lvl_we` pulse sets `pwm_out[i]` to `lvl_val[i]`. While `out_en[i]` is high, `lvl_we` has no effect on that pin.
- R11: When `start_trig` and `stop_trig` arrive together, stop wins: the group stays stopped and the counters keep their values.
- R12: A slave value equal to M gives a pin that is low for exactly one tick per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count tick enable |
| start_trig | input | 1 | Start all channels (single-cycle pulse) |
| stop_trig | input | 1 | Stop all channels (single-cycle pulse) |
| wr_en | input | 1 | Data register write strobe |
| wr_ch | input | 2 | Write target: 0 master, 1 slave A, 2 slave B |
| wr_data | input | 16 | Write value |
| out_en | input | 2 | Per-pin timer output enable |
| lvl_we | input | 1 | Direct pin level write strobe |
| lvl_val | input | 2 | Direct pin levels |
| mst_count | output | 16 | Master counter value |
| slv_count | output | 32 | Slave counters, slave A in bits 15:0 |
| period_irq | output | 1 | One-cycle master period pulse |
| pwm_out | output | 2 | PWM pins, bit 0 from slave A |

## Verification
The main function is exercised with three (M, A, B) settings. A mid-range duty and a near-full duty (5,2,4) show the rise one tick after the event and the exact fall tick. A zero width paired with a width equal to the period minus one (4,0,4) separates a never-active pin from one with a single low tick. Widths beyond the period (3,4,9) must produce a steady high level, which catches any glitch at the period boundary. A separate run rewrites the master and slave A data mid-period. It tells apart an immediate update from one that waits for the next master event, by checking the master counter after the reload and the new pulse width.

// File: rtl/plpwm_pkg.sv
`timescale 1ns/1ps
// Shared constants for the phase-locked PWM timer group.
// Assumes at most three write targets, so the write select is two bits.
package plpwm_pkg;
    localparam int SEL_W = 2;
    typedef enum logic [SEL_W-1:0] {
        CH_MASTER = 2'd0,
        CH_SLV_A  = 2'd1,
        CH_SLV_B  = 2'd2,
        CH_NONE   = 2'd3
    } ch_sel_e;
endpackage

// File: rtl/plpwm_regbank.sv
`timescale 1ns/1ps
// Data (reload) registers for the master and every slave.
// Assumes the write select names the master as 0 and slave i as i+1.
// Values are only consumed at load events, so writes never disturb a period.
module plpwm_regbank
    import plpwm_pkg::*;
#(
    parameter int W    = 16,
    parameter int NSLV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_ch,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      mst_data,
    output logic [NSLV*W-1:0] slv_data
);
    // Master reload register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mst_data <= '0;
        else if (wr_en && wr_ch == CH_MASTER)
            mst_data <= wr_data;
    end

    for (genvar i = 0; i < NSLV; i++) begin : g_slv_reg
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i + 1);
        // Slave i width register write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slv_data[i*W +: W] <= '0;
            else if (wr_en && wr_ch == MY_SEL)
                slv_data[i*W +: W] <= wr_data;
        end
    end
endmodule

// File: rtl/plpwm_run_ctrl.sv
`timescale 1ns/1ps
// Shared run flag and count tick for all channels.
// Assumes start and stop are single-cycle pulses. Stop wins over start.
// An edge that carries either trigger is never a count tick.
module plpwm_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en,
    input  logic start_trig,
    input  logic stop_trig,
    output logic load,
    output logic tick
);
    logic running;

    // Run flag: set by start, cleared by stop (stop has priority).
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (stop_trig)
            running <= 1'b0;
        else if (start_trig)
            running <= 1'b1;
    end

    // Load strobe and count tick for this edge.
    always_comb begin
        load = start_trig && !stop_trig;
        tick = running && cnt_en && !start_trig && !stop_trig;
    end
endmodule

// File: rtl/plpwm_master.sv
`timescale 1ns/1ps
// Master channel: a down-counter that reloads from its data value when a tick
// finds it at zero. That tick is the master event; the period pulse follows it
// by one clock. Assumes load and tick are never high on the same edge.
module plpwm_master #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         tick,
    input  logic [W-1:0] data,
    output logic [W-1:0] count,
    output logic         evt,
    output logic         irq
);
    localparam logic [W-1:0] ONE = W'(1);

    // Master event: a tick taken while the counter sits at zero.
    always_comb evt = tick && (count == '0);

    // Counter: load on start, reload at the event, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= data;
        else if (evt)
            count <= data;
        else if (tick)
            count <= count - ONE;
    end

    // Registered period pulse, one clock long per event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= evt;
    end
endmodule

// File: rtl/plpwm_slave.sv
`timescale 1ns/1ps
// Slave channel: a one-shot down-counter that the master event restarts.
// The load happens at the event; on the next tick the pin rises and counting
// begins. A tick that finds the counter at zero drops the pin and ends the
// shot. A new event that arrives before zero keeps the pin high, so widths
// of a full period or more stay high without a gap. The timer drives the pin
// only while oe is high; while oe is low the pin takes direct writes.
module plpwm_slave #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic         mevt,
    input  logic [W-1:0] data,
    input  logic         oe,
    input  logic         lvl_we,
    input  logic         lvl_val,
    output logic [W-1:0] count,
    output logic         pin
);
    localparam logic [W-1:0] ONE = W'(1);

    logic pend;       // loaded at an event, waiting for the rising tick
    logic busy;       // counting with the pin active
    logic tmr_upd;    // timer wants to set the pin this edge
    logic tmr_lvl;    // level the timer wants

    // Timer's pin decision for this edge.
    always_comb begin
        tmr_upd = 1'b0;
        tmr_lvl = pin;
        if (restart) begin
            tmr_upd = 1'b0;
        end else if (mevt) begin
            tmr_upd = 1'b1;
            if (data == '0)
                tmr_lvl = 1'b0;
            else if (pend)
                tmr_lvl = 1'b1;
            else if (busy && count == '0)
                tmr_lvl = 1'b0;
            else
                tmr_lvl = pin;
        end else if (tick) begin
            if (pend) begin
                tmr_upd = 1'b1;
                tmr_lvl = 1'b1;
            end else if (busy && count == '0) begin
                tmr_upd = 1'b1;
                tmr_lvl = 1'b0;
            end
        end
    end

    // Shot state and counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pend  <= 1'b0;
            busy  <= 1'b0;
        end else if (restart) begin
            pend <= 1'b0;
            busy <= 1'b0;
        end else if (mevt) begin
            count <= data;
            pend  <= (data != '0);
            busy  <= 1'b0;
        end else if (tick) begin
            if (pend) begin
                count <= count - ONE;
                pend  <= 1'b0;
                busy  <= 1'b1;
            end else if (busy) begin
                if (count == '0)
                    busy <= 1'b0;
                else
                    count <= count - ONE;
            end
        end
    end

    // Pin register: timer while enabled, direct writes while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else if (oe && tmr_upd)
            pin <= tmr_lvl;
        else if (!oe && lvl_we)
            pin <= lvl_val;
    end
endmodule

// File: rtl/phase_locked_pwm.sv
`timescale 1ns/1ps
// Top of the phase-locked PWM timer group: one master channel sets the
// period and NSLV slave channels each drive one PWM pin. Assumes cnt_en is
// already synchronous to clk and that NSLV is at most 3 (two-bit select).
module phase_locked_pwm
    import plpwm_pkg::*;
#(
    parameter int W    = 16,
    parameter int NSLV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_ch,
    input  logic [W-1:0]      wr_data,
    input  logic [NSLV-1:0]   out_en,
    input  logic              lvl_we,
    input  logic [NSLV-1:0]   lvl_val,
    output logic [W-1:0]      mst_count,
    output logic [NSLV*W-1:0] slv_count,
    output logic              period_irq,
    output logic [NSLV-1:0]   pwm_out
);
    logic [W-1:0]      mst_data;
    logic [NSLV*W-1:0] slv_data;
    logic              load;
    logic              tick;
    logic              mevt;

    plpwm_regbank #(.W(W), .NSLV(NSLV)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .mst_data (mst_data),
        .slv_data (slv_data)
    );

    plpwm_run_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .start_trig (start_trig),
        .stop_trig  (stop_trig),
        .load       (load),
        .tick       (tick)
    );

    plpwm_master #(.W(W)) mst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .tick  (tick),
        .data  (mst_data),
        .count (mst_count),
        .evt   (mevt),
        .irq   (period_irq)
    );

    for (genvar i = 0; i < NSLV; i++) begin : g_slv
        plpwm_slave #(.W(W)) slv_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (load),
            .tick    (tick),
            .mevt    (mevt),
            .data    (slv_data[i*W +: W]),
            .oe      (out_en[i]),
            .lvl_we  (lvl_we),
            .lvl_val (lvl_val[i]),
            .count   (slv_count[i*W +: W]),
            .pin     (pwm_out[i])
        );
    end
endmodule

// File: rtl/plpwm_checker.sv
`timescale 1ns/1ps
// Port-level properties of the timer group, attached to every instance.
module plpwm_checker #(
    parameter int W    = 16,
    parameter int NSLV = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              start_trig,
    input logic              stop_trig,
    input logic [NSLV-1:0]   out_en,
    input logic              lvl_we,
    input logic [NSLV-1:0]   lvl_val,
    input logic [W-1:0]      mst_count,
    input logic [NSLV*W-1:0] slv_count,
    input logic              period_irq,
    input logic [NSLV-1:0]   pwm_out
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !start_trig) |=> ($stable(mst_count) && $stable(slv_count))); // R9

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_trig |=> ($stable(mst_count) && $stable(slv_count))); // R8

    AST_IRQ_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> ($past(mst_count) == '0 && $past(cnt_en) && !$past(start_trig))); // R3

    for (genvar i = 0; i < NSLV; i++) begin : g_pin
        AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_en[i] && lvl_we) |=> (pwm_out[i] == $past(lvl_val[i]))); // R10

        AST_ENABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en[i] && !cnt_en) |=> $stable(pwm_out[i])); // R10
    end
endmodule

bind phase_locked_pwm plpwm_checker #(.W(W), .NSLV(NSLV)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .start_trig (start_trig),
    .stop_trig  (stop_trig),
    .out_en     (out_en),
    .lvl_we     (lvl_we),
    .lvl_val    (lvl_val),
    .mst_count  (mst_count),
    .slv_count  (slv_count),
    .period_irq (period_irq),
    .pwm_out    (pwm_out)
);

// File: tb/phase_locked_pwm_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected per-cycle state of each
// pattern and the monitor compares it at every falling edge.
module phase_locked_pwm_tb_top;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b1;
    logic          start_trig = 1'b0;
    logic          stop_trig = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_ch = 2'd0;
    logic [W-1:0]  wr_data = '0;
    logic [1:0]    out_en = 2'b11;
    logic          lvl_we = 1'b0;
    logic [1:0]    lvl_val = 2'b00;
    logic [W-1:0]  mst_count;
    logic [2*W-1:0] slv_count;
    logic          period_irq;
    logic [1:0]    pwm_out;

    int checks = 0;
    int errors = 0;
    logic mon_on = 1'b0;

    typedef struct {
        int    mst;
        int    irq;
        int    pwm;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    phase_locked_pwm #(.W(W), .NSLV(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .start_trig (start_trig),
        .stop_trig  (stop_trig),
        .wr_en      (wr_en),
        .wr_ch      (wr_ch),
        .wr_data    (wr_data),
        .out_en     (out_en),
        .lvl_we     (lvl_we),
        .lvl_val    (lvl_val),
        .mst_count  (mst_count),
        .slv_count  (slv_count),
        .period_irq (period_irq),
        .pwm_out    (pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (mon_on && exp_q.size() != 0) begin
            cur = exp_q.pop_front();
            check({cur.tag, " master count"}, int'(mst_count), cur.mst);
            check({cur.tag, " period pulse"}, int'(period_irq), cur.irq);
            check({cur.tag, " pins"}, int'(pwm_out), cur.pwm);
        end
    end

    task automatic wr(input logic [1:0] ch, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch; wr_data = W'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Stop the group and force both pins low through the direct path.
    task automatic quiesce();
        @(negedge clk);
        stop_trig = 1'b1;
        @(negedge clk);
        stop_trig = 1'b0;
        out_en = 2'b00; lvl_we = 1'b1; lvl_val = 2'b00;
        @(negedge clk);
        lvl_we = 1'b0; out_en = 2'b11;
    endtask

    function automatic int pin_exp(input int n, input int m, input int s);
        int p;
        if (n <= m + 1) return 0;
        p = (n - (m + 1)) % (m + 1);
        if (p == 0) return (s >= m + 1) ? 1 : 0;
        return (p <= s) ? 1 : 0;
    endfunction

    // Driver: program a pattern, queue its expected trace, then start it.
    task automatic run_pattern(input int m, input int sa, input int sb,
                               input int periods, input string tag);
        int total;
        exp_t e;
        quiesce();
        wr(2'd0, m); wr(2'd1, sa); wr(2'd2, sb);
        total = (m + 1) * (periods + 1) + 2;
        for (int n = 0; n < total; n++) begin
            e.mst = m - (n % (m + 1));
            e.irq = (n >= m + 1 && (n % (m + 1)) == 0) ? 1 : 0;
            e.pwm = pin_exp(n, m, sa) | (pin_exp(n, m, sb) << 1);
            e.tag = tag;
            exp_q.push_back(e);
        end
        start_trig = 1'b1;
        @(posedge clk);
        #1 start_trig = 1'b0;
        mon_on = 1'b1;
        wait (exp_q.size() == 0);
        #1 mon_on = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0]   held_m;
        logic [2*W-1:0] held_s;
        logic [1:0]     held_p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 master count", int'(mst_count), 0);
        check("R1 slave counts", int'(slv_count != '0), 0);
        check("R1 period pulse", int'(period_irq), 0);
        check("R1 pins", int'(pwm_out), 0);
        repeat (3) @(negedge clk);
        check("R1 idle after reset", int'(mst_count), 0);

        // R2 R3 R4: mid duty and near-full duty
        run_pattern(5, 2, 4, 3, "R2 R3 R4 m5 a2 b4");
        // R5 R12: zero width and width equal to M
        run_pattern(4, 0, 4, 3, "R5 R12 m4 a0 b4");
        // R6: widths beyond the period
        run_pattern(3, 4, 9, 4, "R6 m3 a4 b9");

        // R9: count enable low freezes everything, then counting resumes
        @(negedge clk);
        cnt_en = 1'b0;
        held_m = mst_count; held_s = slv_count; held_p = pwm_out;
        repeat (4) @(negedge clk);
        check("R9 master held", int'(mst_count), int'(held_m));
        check("R9 slaves held", int'(slv_count == held_s), 1);
        check("R9 pins held", int'(pwm_out), int'(held_p));
        cnt_en = 1'b1;
        @(negedge clk);
        check("R9 resumes", int'(mst_count), (held_m == 0) ? 3 : int'(held_m) - 1);

        // R8: stop freezes counters and pins
        @(negedge clk);
        stop_trig = 1'b1;
        held_m = mst_count; held_s = slv_count; held_p = pwm_out;
        @(negedge clk);
        stop_trig = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 master frozen", int'(mst_count), int'(held_m));
        check("R8 slaves frozen", int'(slv_count == held_s), 1);
        check("R8 pins frozen", int'(pwm_out), int'(held_p));

        // R11: simultaneous start and stop leaves the group stopped
        wr(2'd0, 9);
        @(negedge clk);
        start_trig = 1'b1; stop_trig = 1'b1;
        @(negedge clk);
        start_trig = 1'b0; stop_trig = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 no load no count", int'(mst_count), int'(held_m));

        // R10: direct level while disabled, ignored while enabled
        out_en = 2'b00; lvl_we = 1'b1; lvl_val = 2'b01;
        @(negedge clk);
        lvl_we = 1'b0;
        check("R10 forced level", int'(pwm_out), 1);
        out_en = 2'b11; lvl_we = 1'b1; lvl_val = 2'b10;
        @(negedge clk);
        lvl_we = 1'b0;
        @(negedge clk);
        check("R10 write ignored when enabled", int'(pwm_out), 1);

        // R7: mid-period rewrite only takes effect at the next master event
        quiesce();
        wr(2'd0, 7); wr(2'd1, 3); wr(2'd2, 1);
        start_trig = 1'b1;
        @(posedge clk);
        #1 start_trig = 1'b0;
        for (int n = 0; n <= 10; n++) begin
            @(negedge clk);
            if (n == 0) begin
                check("R2 start loads master", int'(mst_count), 7);
                wr_en = 1'b1; wr_ch = 2'd0; wr_data = 16'd2;
            end else if (n == 1) begin
                wr_ch = 2'd1; wr_data = 16'd1;
            end else if (n == 2) begin
                wr_en = 1'b0;
                check("R7 current period unchanged", int'(mst_count), 5);
            end else if (n == 7) begin
                check("R7 old period reaches zero", int'(mst_count), 0);
            end else if (n == 8) begin
                check("R7 reload uses new value", int'(mst_count), 2);
            end else if (n == 9) begin
                check("R7 new width rises", int'(pwm_out[0]), 1);
            end else if (n == 10) begin
                check("R7 new width of one tick ends", int'(pwm_out[0]), 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule